// File: doc/BRIEF.md
# Saturating Clear-on-Read Cell Counter

This block keeps a statistics count of received cells that software reads one byte at a time. A single-cycle pulse marks each cell written into the receive FIFO. Three classification flags come with the pulse: idle, uncorrectable header error and rejected by the user filter. A cell is counted only when the pulse is high and all three flags are low.

The count is read through a byte-wide register port. Reading the most significant byte does three things in one cycle. It captures the whole count into a holding register. It returns the top byte. It restarts the live counter. The reads of the remaining bytes then return slices of the held copy, so software always sees one coherent value, even though cells keep arriving between its byte reads. The counter sticks at all-ones instead of wrapping.

Top module: `cell_tally_top`

## Requirements
- R1: The count is CNT_W bits wide (default 32), read as CNT_W/8 bytes. Address 0 returns bits CNT_W-1:CNT_W-8, and address k (1 <= k < CNT_W/8) returns bits (CNT_W/8-1-k)*8+7 : (CNT_W/8-1-k)*8 of the value captured at the last address-0 read.
- R2: After the synchronous active-low reset, rd_data is 0x00 and every byte of the count reads 0x00.
- R3: A cycle with cell_wr high and cell_idle, cell_hec_bad and cell_filtered all low adds exactly one to the count. A cycle with cell_wr low adds nothing.
- R4: A cell flagged idle (cell_idle high) is not counted.
- R5: A cell flagged with an uncorrectable header error (cell_hec_bad high) is not counted.
- R6: A cell flagged as rejected by the user filter (cell_filtered high) is not counted.
- R7: The count saturates at all ones and stays there until a clearing read. It never wraps to zero.
- R8: A read of address 0 clears the count, so the next read sequence returns only the cells accepted since the previous address-0 read.
- R9: Cells accepted after an address-0 read do not change the bytes returned by later reads of addresses 1 to CNT_W/8-1.
- R10: A cell accepted in the same cycle as an address-0 read is not lost. It becomes the first count of the new interval, so the live count is 1.
- R11: rd_data is updated on the clock edge that samples rd_stb high, and it keeps its value while rd_stb stays low.
- R12: Reads of addresses 1 and above do not clear the count. Addresses at or beyond CNT_W/8 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_wr | input | 1 | One-cycle pulse per cell written to the receive FIFO |
| cell_idle | input | 1 | The cell is an idle cell |
| cell_hec_bad | input | 1 | The cell had an uncorrectable header error |
| cell_filtered | input | 1 | The cell was rejected by the user filter |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Byte address within the counter group |
| rd_data | output | 8 | Read data, valid the cycle after rd_stb |

## Verification
The hardest case to reach is saturation, because it needs the full range of the counter to be filled. The bench therefore uses a 16-bit build and drives a long unbroken burst of cell pulses past 0xFFFF. A default-width build shares the same stimulus, so the same burst checks its byte order without saturation. The clearing read in that burst arrives in the same cycle as another accepted cell, which tests the saturated capture and the restart at 1 together. Cells that arrive between the byte reads of one sequence test the coherence of the held copy.

// File: rtl/cell_tally_pkg.sv
// Package: shared constants and helpers for the cell tally block.
// Assumes byte-wide register access and a counter width that is a multiple of 8.
package cell_tally_pkg;

    localparam int BYTE_W = 8;

    // Number of byte registers needed for a counter of the given width.
    function automatic int byte_count(input int width);
        return width / BYTE_W;
    endfunction

endpackage

// File: rtl/cell_qual.sv
// Module: cell_qual
// Decides whether the cell pulse of this cycle counts. A cell counts only
// when the write pulse is high and none of the discard or idle flags is set.
// Assumes the flags are valid in the same cycle as cell_wr.
module cell_qual (
    input  logic cell_wr,
    input  logic cell_idle,
    input  logic cell_hec_bad,
    input  logic cell_filtered,
    output logic cell_count
);

    // Combine the pulse and the three rejection flags.
    always_comb begin
        cell_count = cell_wr & ~(cell_idle | cell_hec_bad | cell_filtered);
    end

endmodule

// File: rtl/sat_tally.sv
// Module: sat_tally
// Live saturating counter. A clear reloads it with the increment of the
// same cycle, so a cell that coincides with a clear is kept.
// Assumes clr and inc are single-cycle, synchronous to clk.
module sat_tally #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;

    // Flag the saturation value.
    always_comb begin
        at_max = (cnt == CNT_MAX);
    end

    // Count up, saturate, or restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_W'(1) : '0;
        end else if (inc && !at_max) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R7: once saturated, stays saturated until a clear.
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));

    // R10: a clear reloads with the coincident increment.
    p_clr_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == CNT_W'($past(inc))));

    // R3: an accepted cell below saturation adds exactly one.
    p_inc_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R12: without a clear or a cell the count does not move.
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/snap_readout.sv
// Module: snap_readout
// Byte read port. Address 0 returns the live top byte, captures the rest of
// the live count into a holding register and requests a clear. Other
// addresses return bytes of the held copy, and unmapped addresses return 0.
// Assumes 2**ADDR_W >= CNT_W/8 and CNT_W >= 16.
module snap_readout
    import cell_tally_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  live,
    output logic              clr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int NBYTES = byte_count(CNT_W);
    localparam int HOLD_W = CNT_W - BYTE_W;

    logic [HOLD_W-1:0] hold;
    logic [BYTE_W-1:0] sel;

    // A read of the top byte is the clearing read.
    always_comb begin
        clr = rd_stb && (rd_addr == '0);
    end

    // Pick the byte for the addressed register.
    always_comb begin
        sel = '0;
        if (rd_addr == '0) begin
            sel = live[CNT_W-1 -: BYTE_W];
        end else begin
            for (int k = 1; k < NBYTES; k++) begin
                if (rd_addr == ADDR_W'(k)) begin
                    sel = hold[(NBYTES-1-k)*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    // Capture the lower bytes of the live count on the clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (clr) begin
            hold <= live[HOLD_W-1:0];
        end
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= sel;
        end
    end

    // R9: the holding register takes the live count at the clearing read.
    p_snap_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (hold == $past(live[HOLD_W-1:0])));

    // R9: without a clearing read the held copy does not change.
    p_snap_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(hold));

    // R1: address 0 returns the top byte of the live count.
    p_msb_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_data == $past(live[CNT_W-1 -: BYTE_W])));

    // R11: read data holds while no strobe is present.
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

endmodule

// File: rtl/cell_tally_top.sv
// Module: cell_tally_top
// Saturating clear-on-read cell counter with a byte-wide read port.
// Assumes cell_wr is one cycle per cell and that the read strobe is one cycle
// per access. Reset is synchronous and active low.
module cell_tally_top #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_wr,
    input  logic              cell_idle,
    input  logic              cell_hec_bad,
    input  logic              cell_filtered,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic             accept;
    logic             clr;
    logic [CNT_W-1:0] live;

    cell_qual u_qual (
        .cell_wr       (cell_wr),
        .cell_idle     (cell_idle),
        .cell_hec_bad  (cell_hec_bad),
        .cell_filtered (cell_filtered),
        .cell_count    (accept)
    );

    sat_tally #(.CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept),
        .clr   (clr),
        .cnt   (live)
    );

    snap_readout #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .live    (live),
        .clr     (clr),
        .rd_data (rd_data)
    );

    // R4/R5/R6: a flagged cell never counts.
    p_flagged_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_idle || cell_hec_bad || cell_filtered) |-> !accept);

    // R2: the cycle after reset the live count is zero.
    p_reset_zero_r2: assert property (@(posedge clk)
        !rst_n |=> (live == '0 && rd_data == 8'h00));

endmodule

// File: tb/cell_tally_top_test.sv
module cell_tally_top_test;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, cell_wr, cell_idle, cell_hec_bad, cell_filtered, rd_stb;
    logic [1:0] rd_addr;
    logic [7:0] rd_s, rd_w;

    int     checks = 0;
    int     fails  = 0;
    longint n_model = 0;
    bit     done = 0;

    // Small build used for saturation, default build for byte order.
    cell_tally_top #(.CNT_W(16), .ADDR_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .cell_wr(cell_wr), .cell_idle(cell_idle),
        .cell_hec_bad(cell_hec_bad), .cell_filtered(cell_filtered),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_s));

    cell_tally_top uut_wide (
        .clk(clk), .rst_n(rst_n), .cell_wr(cell_wr), .cell_idle(cell_idle),
        .cell_hec_bad(cell_hec_bad), .cell_filtered(cell_filtered),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_w));

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic drive_cell(input bit w, input bit i, input bit h, input bit f);
        @(negedge clk);
        cell_wr = w; cell_idle = i; cell_hec_bad = h; cell_filtered = f;
        if (w && !i && !h && !f) n_model++;
        @(negedge clk);
        cell_wr = 0; cell_idle = 0; cell_hec_bad = 0; cell_filtered = 0;
    endtask

    task automatic burst(input int n);
        @(negedge clk);
        cell_wr = 1; cell_idle = 0; cell_hec_bad = 0; cell_filtered = 0;
        repeat (n) @(negedge clk);
        cell_wr = 0;
        n_model += n;
    endtask

    task automatic read_byte(input int a, input bit q,
                             output logic [7:0] s, output logic [7:0] w);
        @(negedge clk);
        rd_stb = 1; rd_addr = 2'(a);
        if (q) begin
            cell_wr = 1; cell_idle = 0; cell_hec_bad = 0; cell_filtered = 0;
        end
        @(negedge clk);
        rd_stb = 0; cell_wr = 0;
        s = rd_s; w = rd_w;
    endtask

    // Full read sequence; q puts an accepted cell on the clearing read.
    task automatic read_all(input string req, input bit q);
        logic [7:0] s [4];
        logic [7:0] w [4];
        longint exp_w, exp_s;
        exp_w = n_model;
        exp_s = (n_model > 65535) ? 65535 : n_model;
        for (int a = 0; a < 4; a++) read_byte(a, (a == 0) && q, s[a], w[a]);
        n_model = q ? 1 : 0;
        chk({req, " narrow"}, {s[0], s[1]}, exp_s);
        chk({req, " wide"}, {w[0], w[1], w[2], w[3]}, exp_w);
        chk("R12 unmapped bytes", {s[2], s[3]}, 0);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] s, w, keep;
        string tag;
        rst_n = 0; cell_wr = 0; cell_idle = 0; cell_hec_bad = 0;
        cell_filtered = 0; rd_stb = 0; rd_addr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 rd_data after reset", {rd_s, rd_w}, 0);
        read_all("R2 count after reset", 0);

        // R3: plain accepted cells.
        for (int k = 0; k < 5; k++) drive_cell(1, 0, 0, 0);
        read_all("R3 five cells", 0);

        // R3-R6 flag sweep: every combination of pulse and flags.
        for (int c = 0; c < 16; c++) begin
            for (int r = 0; r < 3; r++) drive_cell(c[3], c[2], c[1], c[0]);
            if (!c[3])     tag = "R3 no pulse";
            else if (c[2]) tag = "R4 idle";
            else if (c[1]) tag = "R5 hec";
            else if (c[0]) tag = "R6 filtered";
            else           tag = "R3 accepted";
            read_all(tag, 0);
        end

        // R8: counts since previous read, mixed with idle cells.
        for (int k = 0; k <= 40; k++) begin
            for (int j = 0; j < k; j++) begin
                drive_cell(1, 0, 0, 0);
                drive_cell(1, 1, 0, 0);
            end
            read_all("R8 interval count", 0);
        end

        // R9: cells between byte reads do not disturb the held copy.
        burst(300);
        read_byte(0, 0, s, w);
        chk("R1 top byte", {s, w}, 16'h0100);
        n_model = 0;
        burst(300);
        read_byte(1, 0, s, w);
        chk("R9 byte1 held", {s, w}, 16'h2C00);
        read_byte(2, 0, s, w);
        chk("R9 byte2 held", w, 8'h01);
        read_byte(3, 0, s, w);
        chk("R9 byte3 held", w, 8'h2C);
        keep = rd_w;
        repeat (5) @(negedge clk);
        chk("R11 read data holds", rd_w, keep);
        read_all("R8 after snapshot", 0);

        // R12: non-zero addresses do not clear.
        for (int k = 0; k < 7; k++) drive_cell(1, 0, 0, 0);
        for (int a = 1; a < 4; a++) read_byte(a, 0, s, w);
        read_all("R12 no clear on other bytes", 0);

        // R10: cell coincident with the clearing read.
        for (int k = 0; k < 4; k++) drive_cell(1, 0, 0, 0);
        read_all("R10 before", 1);
        drive_cell(1, 0, 0, 0);
        drive_cell(1, 0, 0, 0);
        read_all("R10 next interval", 0);

        // R7: saturate the narrow build; wide build checks R1 byte order.
        burst(65540);
        read_all("R7 saturation / R1 order", 1);
        read_all("R10 after saturated read", 0);

        done = 1;
        summary();
        $finish;
    end

endmodule